// File: doc/BRIEF.md
# Snake-order mesh sorter

The block holds a square grid of keys, one per cell, and sorts them into snake row-major order. In that order, even-numbered rows read smallest to largest from left to right. Odd-numbered rows read smallest to largest from right to left. The last key of each row is no larger than the first key, in snake order, of the row below it. The sort follows the shearsort schedule. Row phases and column phases alternate for log2(ROWS) rounds, and one more row phase closes the sort. Each phase is an odd-even transposition sort of ROWS compare-exchange steps, and every comparison is between two neighbouring cells.

A host writes the whole matrix in one cycle and pulses start. It then waits for the done flag and reads the sorted matrix in parallel. A controller counts steps and phases and drives the grid datapath through a small strobe struct. Each step is one clock cycle, so a sort takes (2·log2(ROWS)+1)·ROWS cycles.

Top module: `shear_mesh_sorter`

## Requirements
- R1: While rstN is low and after its release, done is 0 and every key of keysOut is 0.
- R2: A loadEn pulse while the sorter is idle writes keysIn into the grid. The new keys show on keysOut in the next cycle. Cell (row i, column j) occupies bits [(i·ROWS+j)·KEY_W +: KEY_W] of both buses.
- R3: A loadEn pulse while a sort is running is ignored. The result is the sorted form of the keys that were in the grid when that sort started.
- R4: When done rises, keysOut holds the loaded multiset in snake order. Snake position k maps to row k/ROWS. Within that row, k%ROWS is counted from the left on even rows and from the right on odd rows. Keys rise with k.
- R5: done rises exactly (2·log2(ROWS)+1)·ROWS clock cycles after the edge that accepts start. For ROWS=4 this is 20 cycles.
- R6: Once set, done and keysOut hold steady until the next start or load. An accepted start clears done in the next cycle.
- R7: If loadEn and start fall in the same idle cycle, the sort runs on the newly loaded keys.
- R8: A start pulse while a sort is running is ignored, so done still rises at the time set by the first start.
- R9: Duplicate keys, the extreme values 0 and 2^KEY_W−1, and input that is already in order or fully reversed are all sorted correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| loadEn | input | 1 | Write keysIn into the grid (idle only) |
| keysIn | input | ROWS·ROWS·KEY_W | Parallel key matrix to load |
| start | input | 1 | Begin a sort (idle only) |
| keysOut | output | ROWS·ROWS·KEY_W | Parallel view of the grid |
| done | output | 1 | Sort finished; held until next start |

## Verification
Two functions can fall in the same cycle. A matrix load can coincide with the acceptance of start, and a load or a second start can coincide with a running sort. The bench drives loadEn and start in the same idle cycle and expects the newly loaded keys to come out sorted. It also raises loadEn with different data, and a second start, in the middle of a sort. There it expects the original keys sorted and done at exactly the cycle count set by the first start. Results are compared with a snake arrangement that the bench builds itself by sorting the loaded keys.

// File: rtl/shear_pkg.sv
package shear_pkg;
  typedef struct packed {
    logic load;      // capture keysIn into the grid
    logic step;      // perform one compare-exchange step
    logic colPhase;  // 1: column phase, 0: row phase
    logic oddPair;   // 1: pairs (1,2),(3,4)..., 0: pairs (0,1),(2,3)...
  } shear_ctl_t;
endpackage

// File: rtl/shear_ctrl.sv
module shear_ctrl
  import shear_pkg::*;
#(
  parameter int ROWS = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loadEn,
  input  logic       start,
  output shear_ctl_t ctl,
  output logic       busy,
  output logic       done
);
  localparam int LOG_R  = $clog2(ROWS);
  localparam int PHASES = 2 * LOG_R + 1;
  localparam int STEP_W = (ROWS > 2) ? $clog2(ROWS) : 1;
  localparam int PH_W   = $clog2(PHASES + 1);

  logic [STEP_W-1:0] stepCnt;
  logic [PH_W-1:0]   phaseCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      stepCnt  <= '0;
      phaseCnt <= '0;
    end else if (start && !busy) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      stepCnt  <= '0;
      phaseCnt <= '0;
    end else if (busy) begin
      if (stepCnt == STEP_W'(ROWS - 1)) begin
        stepCnt <= '0;
        if (phaseCnt == PH_W'(PHASES - 1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          phaseCnt <= phaseCnt + 1'b1;
        end
      end else begin
        stepCnt <= stepCnt + 1'b1;
      end
    end
  end

  always_comb begin
    ctl.load     = loadEn && !busy;
    ctl.step     = busy;
    ctl.colPhase = phaseCnt[0];
    ctl.oddPair  = stepCnt[0];
  end
endmodule

// File: rtl/shear_grid.sv
module shear_grid
  import shear_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int KEY_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  shear_ctl_t                 ctl,
  input  logic [ROWS*ROWS*KEY_W-1:0] keysIn,
  output logic [ROWS*ROWS*KEY_W-1:0] keysOut
);
  logic [KEY_W-1:0] cellQ [ROWS][ROWS];
  logic [KEY_W-1:0] cellD [ROWS][ROWS];

  // Compare-exchange network: each cell only meets its row or column neighbour.
  always_comb begin
    for (int i = 0; i < ROWS; i++)
      for (int j = 0; j < ROWS; j++)
        cellD[i][j] = cellQ[i][j];
    if (ctl.colPhase) begin
      for (int j = 0; j < ROWS; j++)
        for (int i = 0; i + 1 < ROWS; i++)
          if ((i % 2) == int'(ctl.oddPair) && cellQ[i][j] > cellQ[i+1][j]) begin
            cellD[i][j]   = cellQ[i+1][j];
            cellD[i+1][j] = cellQ[i][j];
          end
    end else begin
      for (int i = 0; i < ROWS; i++)
        for (int j = 0; j + 1 < ROWS; j++)
          if ((j % 2) == int'(ctl.oddPair) &&
              (((i % 2) == 0) ? (cellQ[i][j] > cellQ[i][j+1])
                              : (cellQ[i][j] < cellQ[i][j+1]))) begin
            cellD[i][j]   = cellQ[i][j+1];
            cellD[i][j+1] = cellQ[i][j];
          end
    end
  end

  generate
    for (genvar gi = 0; gi < ROWS; gi++) begin : g_row
      for (genvar gj = 0; gj < ROWS; gj++) begin : g_col
        localparam int IDX = gi * ROWS + gj;
        always_ff @(posedge clk) begin
          if (!rstN)
            cellQ[gi][gj] <= '0;
          else if (ctl.load)
            cellQ[gi][gj] <= keysIn[IDX*KEY_W +: KEY_W];
          else if (ctl.step)
            cellQ[gi][gj] <= cellD[gi][gj];
        end
        assign keysOut[IDX*KEY_W +: KEY_W] = cellQ[gi][gj];
      end
    end
  endgenerate
endmodule

// File: rtl/shear_mesh_sorter.sv
module shear_mesh_sorter
  import shear_pkg::*;
#(
  parameter int ROWS  = 4,
  parameter int KEY_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       loadEn,
  input  logic [ROWS*ROWS*KEY_W-1:0] keysIn,
  input  logic                       start,
  output logic [ROWS*ROWS*KEY_W-1:0] keysOut,
  output logic                       done
);
  shear_ctl_t ctl;
  logic       busy;

  shear_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .start(start),
    .ctl(ctl), .busy(busy), .done(done)
  );

  shear_grid #(.ROWS(ROWS), .KEY_W(KEY_W)) u_grid (
    .clk(clk), .rstN(rstN), .ctl(ctl), .keysIn(keysIn), .keysOut(keysOut)
  );
endmodule

// File: rtl/shear_checker.sv
module shear_checker #(
  parameter int ROWS  = 4,
  parameter int KEY_W = 8
) (
  input logic                       clk,
  input logic                       rstN,
  input logic                       start,
  input logic                       loadEn,
  input logic                       busy,
  input logic                       done,
  input logic [ROWS*ROWS*KEY_W-1:0] keysOut
);
  localparam int N     = ROWS * ROWS;
  localparam int TOTAL = (2 * $clog2(ROWS) + 1) * ROWS;

  function automatic int snakeIdx(int k);
    int r, c;
    r = k / ROWS;
    c = k % ROWS;
    return r * ROWS + (((r % 2) == 0) ? c : (ROWS - 1 - c));
  endfunction

  function automatic logic snakeOk(logic [N*KEY_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int k = 0; k + 1 < N; k++)
      if (v[snakeIdx(k)*KEY_W +: KEY_W] > v[snakeIdx(k+1)*KEY_W +: KEY_W]) ok = 1'b0;
    return ok;
  endfunction

  logic [15:0] busyCnt;
  always_ff @(posedge clk) begin
    if (!rstN)                busyCnt <= '0;
    else if (start && !busy)  busyCnt <= '0;
    else if (busy)            busyCnt <= busyCnt + 1'b1;
  end

  assert_snake_order_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> snakeOk(keysOut));

  assert_step_count_R5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> busyCnt == 16'(TOTAL));

  assert_done_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  assert_out_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start && !loadEn) |=> $stable(keysOut));

  assert_start_clears_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> (!done && busy));

  assert_no_done_while_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !done);
endmodule

bind shear_mesh_sorter shear_checker #(.ROWS(ROWS), .KEY_W(KEY_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .loadEn(loadEn),
  .busy(busy), .done(done), .keysOut(keysOut)
);

// File: tb/shear_mesh_sorter_bench.sv
module shear_mesh_sorter_bench;
  localparam int ROWS   = 4;
  localparam int KEY_W  = 8;
  localparam int N      = ROWS * ROWS;
  localparam int W      = N * KEY_W;
  localparam int TOTAL  = 20;   // (2*log2(4)+1)*4
  localparam int PERIOD = 10;
  localparam int NVEC   = 4;
  localparam logic [W-1:0] VECS [NVEC] = '{
    128'h3a7c019e55d2b8416f0c93e7284ab51d,   // scattered
    128'h07020702070207020a0a0a0a00ff00ff,   // duplicates and extremes
    128'h00112233445566778899aabbccddeeff,   // reversed
    128'hff00ff00ff0000ffff00ff0000ff00ff    // only 0 and max
  };

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         loadEn = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] keysIn = '0;
  logic [W-1:0] keysOut;
  logic         done;
  int           errors = 0;
  int           checks = 0;

  always #(PERIOD/2) clk = ~clk;

  shear_mesh_sorter #(.ROWS(ROWS), .KEY_W(KEY_W)) u_shear_mesh_sorter (
    .clk(clk), .rstN(rstN), .loadEn(loadEn), .keysIn(keysIn),
    .start(start), .keysOut(keysOut), .done(done)
  );

  function automatic logic [W-1:0] snakeOf(logic [W-1:0] v);
    logic [KEY_W-1:0] k [N];
    logic [KEY_W-1:0] t;
    logic [W-1:0] o;
    for (int a = 0; a < N; a++) k[a] = v[a*KEY_W +: KEY_W];
    for (int a = 0; a < N; a++)
      for (int b = 0; b + 1 < N - a; b++)
        if (k[b] > k[b+1]) begin t = k[b]; k[b] = k[b+1]; k[b+1] = t; end
    o = '0;
    for (int p = 0; p < N; p++) begin
      int r, c;
      r = p / ROWS;
      c = p % ROWS;
      if ((r % 2) == 1) c = ROWS - 1 - c;
      o[(r*ROWS+c)*KEY_W +: KEY_W] = k[p];
    end
    return o;
  endfunction

  task automatic check(input logic ok, input string req, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadKeys(input logic [W-1:0] v);
    @(negedge clk); keysIn = v; loadEn = 1'b1;
    @(negedge clk); loadEn = 1'b0;
  endtask

  // start pulse, then count cycles until done; returns count
  task automatic runSort(output int cyc);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
  endtask

  initial begin
    #(PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int cyc;
    logic [W-1:0] held;
    repeat (3) @(negedge clk);
    check(!done && keysOut == '0, "R1 in reset", keysOut, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && keysOut == '0, "R1 after reset", keysOut, '0);

    // table walk: load, read back, sort, compare with bench-built snake order
    for (int v = 0; v < NVEC; v++) begin
      loadKeys(VECS[v]);
      check(keysOut == VECS[v], "R2 load visible", keysOut, VECS[v]);
      runSort(cyc);
      check(cyc == TOTAL, "R5 cycle count", W'(cyc), W'(TOTAL));
      check(keysOut == snakeOf(VECS[v]), (v >= 1) ? "R9 corner pattern" : "R4 snake order",
            keysOut, snakeOf(VECS[v]));
    end

    // R6: hold after done, then start clears done
    held = keysOut;
    repeat (5) @(negedge clk);
    check(done && keysOut == held, "R6 hold after done", keysOut, held);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(!done, "R6 start clears done", W'(done), '0);
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check(keysOut == held, "R9 sorted input stays sorted", keysOut, held);

    // R7: load and start in the same idle cycle
    @(negedge clk); keysIn = VECS[0]; loadEn = 1'b1; start = 1'b1;
    @(negedge clk); loadEn = 1'b0; start = 1'b0;
    cyc = 0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check(keysOut == snakeOf(VECS[0]), "R7 load with start", keysOut, snakeOf(VECS[0]));
    check(cyc == TOTAL, "R7 cycle count", W'(cyc), W'(TOTAL));

    // R3 and R8: load and second start during a running sort are ignored
    loadKeys(VECS[2]);
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    cyc = 0;
    repeat (3) begin @(negedge clk); cyc++; end
    keysIn = VECS[3]; loadEn = 1'b1; start = 1'b1;
    @(negedge clk); cyc++; loadEn = 1'b0; start = 1'b0;
    while (!done && cyc < 200) begin @(negedge clk); cyc++; end
    check(cyc == TOTAL, "R8 restart ignored", W'(cyc), W'(TOTAL));
    check(keysOut == snakeOf(VECS[2]), "R3 load while busy ignored", keysOut, snakeOf(VECS[2]));

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule